// File: doc/BRIEF.md
# Iterative Multiplier with Low and High Word Results

This block multiplies two words over a fixed number of clock cycles, one shift-and-add step per cycle, and returns a single word of the product. It serves five operations. The first is the low word of the product. The second is the same low word where the second operand is a sign-extended immediate taken from the request. The other three are the high word of the double-width product, with the operands read as unsigned×unsigned, signed×unsigned or signed×signed. A request carries a major opcode, an extended opcode, both register operands and an immediate.

One step loop produces two results at once. It builds the low word by shifting the partial product left and scanning the multiplier from its top bit. In the same cycles it builds the unsigned high word by scanning the multiplier from its bottom bit, adding into an accumulator that shifts right and takes each step's carry back in at its top bit. One correction cycle follows the loop. In that cycle the signed high words are made from the unsigned one: the original second operand is subtracted when A is negative, and then A is subtracted when the original second operand is negative.

The request side is a valid/ready handshake. The block takes a request only while it is idle, and ready stays low until the result has gone out, so a source that holds valid simply waits. The result side has no back-pressure. The result is shown for exactly one cycle with a valid pulse, and the consumer must take it in that cycle.

Top module: `mulx_iter`

## Requirements
- R1: With major opcode 0x3a and extended opcode 0x27, the result is the low W bits of A×B.
- R2: With major opcode 0x24, the second operand is the 16-bit immediate sign-extended to W bits, the extended opcode is not used, and the result is the low W bits of A×sext(imm).
- R3: With major opcode 0x3a and extended opcode 0x07, the result is the upper W bits of the 2W-bit product of A and B, both read as unsigned.
- R4: With major opcode 0x3a and extended opcode 0x17, the result is the upper W bits of the product of A read as signed and B read as unsigned.
- R5: With major opcode 0x3a and extended opcode 0x1f, the result is the upper W bits of the product of A and B, both read as signed.
- R6: Any major opcode other than 0x24 selects the register form. In that form, any extended opcode other than 0x27, 0x07 and 0x17 gives the signed×signed high word of R5.
- R7: Take the clock edge at which a request is accepted (req_valid and req_ready both high) as edge 0. res_valid is then high in the cycle that follows edge W+1 and in no earlier cycle.
- R8: res_valid is high for exactly one cycle per accepted request.
- R9: req_ready is high while idle. It is low from the cycle after acceptance until the cycle after the res_valid pulse. While req_ready is low, req_valid has no effect: the result in flight does not change, and no extra result appears.
- R10: After reset, req_ready is 1 and res_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_major | input | 6 | Major opcode (0x24 immediate form, otherwise register form) |
| req_ext | input | 6 | Extended opcode for the register form |
| req_a | input | W | Operand A (multiplicand) |
| req_b | input | W | Operand B (multiplier in the register form) |
| req_imm | input | 16 | Immediate, sign-extended to become the multiplier in the immediate form |
| res_valid | output | 1 | One-cycle pulse marking the result |
| res_data | output | W | Selected product word |

## Verification
The bench builds the block at its default width of 32, the width at which a 64-bit reference product in the bench gives every expected word exactly. Directed cases place the sign bits of A, B and the immediate on both sides. They also cover all-ones operands, zero, and the most negative value, where both corrections fire together and carries run through the whole high accumulator. Random operands then cover every opcode, including unrecognised extended and major codes. A held request during a busy period shows that back-pressure drops nothing and duplicates nothing.

// File: rtl/mulx_pkg.sv
package mulx_pkg;

  localparam int OPC_W = 6;

  localparam logic [OPC_W-1:0] MAJ_IMM = 6'h24;
  localparam logic [OPC_W-1:0] EXT_LO  = 6'h27;
  localparam logic [OPC_W-1:0] EXT_UU  = 6'h07;
  localparam logic [OPC_W-1:0] EXT_SU  = 6'h17;

  typedef enum logic [1:0] {
    K_LO = 2'd0,
    K_UU = 2'd1,
    K_SU = 2'd2,
    K_SS = 2'd3
  } kind_t;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_RUN  = 2'd1,
    S_FIX  = 2'd2,
    S_DONE = 2'd3
  } state_t;

endpackage

// File: rtl/mulx_decode.sv
module mulx_decode
  import mulx_pkg::*;
#(
  parameter int W     = 32,
  parameter int IMM_W = 16
) (
  input  logic [OPC_W-1:0] major,
  input  logic [OPC_W-1:0] ext,
  input  logic [W-1:0]     b_reg,
  input  logic [IMM_W-1:0] imm,
  output kind_t            kind,
  output logic [W-1:0]     b_sel
);

  localparam int EXT_BITS = W - IMM_W;

  logic imm_form;
  logic [W-1:0] imm_sext;

  assign imm_form = (major == MAJ_IMM);
  assign imm_sext = {{EXT_BITS{imm[IMM_W-1]}}, imm};

  always_comb begin
    b_sel = imm_form ? imm_sext : b_reg;
    if (imm_form) begin
      kind = K_LO;
    end else begin
      case (ext)
        EXT_LO:  kind = K_LO;
        EXT_UU:  kind = K_UU;
        EXT_SU:  kind = K_SU;
        default: kind = K_SS;
      endcase
    end
  end

endmodule

// File: rtl/mulx_loop.sv
module mulx_loop #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] a_q,
  output logic [W-1:0] b_orig,
  output logic [W-1:0] lo_acc,
  output logic [W-1:0] hi_acc
);

  logic [W-1:0] mul_lo;
  logic [W-1:0] mul_hi;
  logic [W:0]   hi_sum;
  logic [W-1:0] lo_next;

  assign hi_sum  = {1'b0, hi_acc} + (mul_hi[0] ? {1'b0, a_q} : '0);
  assign lo_next = {lo_acc[W-2:0], 1'b0} + (mul_lo[W-1] ? a_q : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q    <= '0;
      b_orig <= '0;
      mul_lo <= '0;
      mul_hi <= '0;
      lo_acc <= '0;
      hi_acc <= '0;
    end else if (load) begin
      a_q    <= a_in;
      b_orig <= b_in;
      mul_lo <= b_in;
      mul_hi <= b_in;
      lo_acc <= '0;
      hi_acc <= '0;
    end else if (step) begin
      lo_acc <= lo_next;
      mul_lo <= {mul_lo[W-2:0], 1'b0};
      hi_acc <= hi_sum[W:1];
      mul_hi <= {1'b0, mul_hi[W-1:1]};
    end
  end

endmodule

// File: rtl/mulx_fix.sv
module mulx_fix
  import mulx_pkg::*;
#(
  parameter int W = 32
) (
  input  kind_t        kind,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b_orig,
  input  logic [W-1:0] lo,
  input  logic [W-1:0] hi,
  output logic [W-1:0] result
);

  logic [W-1:0] hi_su;
  logic [W-1:0] hi_ss;

  assign hi_su = hi    - (a[W-1]      ? b_orig : '0);
  assign hi_ss = hi_su - (b_orig[W-1] ? a      : '0);

  always_comb begin
    case (kind)
      K_LO:    result = lo;
      K_UU:    result = hi;
      K_SU:    result = hi_su;
      default: result = hi_ss;
    endcase
  end

endmodule

// File: rtl/mulx_iter.sv
module mulx_iter
  import mulx_pkg::*;
#(
  parameter int W     = 32,
  parameter int IMM_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [OPC_W-1:0] req_major,
  input  logic [OPC_W-1:0] req_ext,
  input  logic [W-1:0]     req_a,
  input  logic [W-1:0]     req_b,
  input  logic [IMM_W-1:0] req_imm,
  output logic             res_valid,
  output logic [W-1:0]     res_data
);

  localparam int CNT_W = $clog2(W + 1);
  localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(W - 1);

  state_t st_q;
  kind_t  kind_d, kind_q;
  logic [CNT_W-1:0] step_cnt;
  logic [W-1:0] b_sel, a_q, b_orig, lo_acc, hi_acc, fixed;
  logic accept, stepping;

  assign req_ready = (st_q == S_IDLE);
  assign accept    = req_valid && req_ready;
  assign stepping  = (st_q == S_RUN);
  assign res_valid = (st_q == S_DONE);

  mulx_decode #(.W(W), .IMM_W(IMM_W)) u_dec (
    .major (req_major),
    .ext   (req_ext),
    .b_reg (req_b),
    .imm   (req_imm),
    .kind  (kind_d),
    .b_sel (b_sel)
  );

  mulx_loop #(.W(W)) u_loop (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (accept),
    .step   (stepping),
    .a_in   (req_a),
    .b_in   (b_sel),
    .a_q    (a_q),
    .b_orig (b_orig),
    .lo_acc (lo_acc),
    .hi_acc (hi_acc)
  );

  mulx_fix #(.W(W)) u_fix (
    .kind   (kind_q),
    .a      (a_q),
    .b_orig (b_orig),
    .lo     (lo_acc),
    .hi     (hi_acc),
    .result (fixed)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= S_IDLE;
      kind_q   <= K_LO;
      step_cnt <= '0;
      res_data <= '0;
    end else begin
      case (st_q)
        S_IDLE: begin
          if (accept) begin
            kind_q   <= kind_d;
            step_cnt <= '0;
            st_q     <= S_RUN;
          end
        end
        S_RUN: begin
          step_cnt <= step_cnt + 1'b1;
          if (step_cnt == LAST_STEP) st_q <= S_FIX;
        end
        S_FIX: begin
          res_data <= fixed;
          st_q     <= S_DONE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/mulx_iter_chk.sv
module mulx_iter_chk #(
  parameter int W = 32
) (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic res_valid
);

  localparam int LAT   = W + 2;
  localparam int LCW   = $clog2(LAT + 2);
  localparam logic [LCW-1:0] LAT_V = LCW'(LAT);
  localparam logic [LCW-1:0] SAT_V = LCW'(LAT + 1);

  logic [LCW-1:0] since_acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_acc <= '0;
    else if (req_valid && req_ready) since_acc <= LCW'(1);
    else if (since_acc != '0 && since_acc != SAT_V) since_acc <= since_acc + 1'b1;
  end

  // R7
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> since_acc == LAT_V);

  // R8
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  // R9
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R9
  busy_at_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !req_ready);

  // R9
  ready_after_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> req_ready);

endmodule

bind mulx_iter mulx_iter_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .res_valid (res_valid)
);

// File: tb/tb_mulx_iter.sv
module tb_mulx_iter;

  localparam int W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [5:0] req_major = 6'h3a;
  logic [5:0] req_ext = 6'h27;
  logic [W-1:0] req_a = '0;
  logic [W-1:0] req_b = '0;
  logic [15:0] req_imm = '0;
  logic res_valid;
  logic [W-1:0] res_data;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  mulx_iter dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_major(req_major), .req_ext(req_ext), .req_a(req_a), .req_b(req_b),
    .req_imm(req_imm), .res_valid(res_valid), .res_data(res_data)
  );

  function automatic logic [W-1:0] model(input logic [5:0] maj, input logic [5:0] ext,
                                         input logic [W-1:0] a, input logic [W-1:0] b,
                                         input logic [15:0] imm);
    logic [63:0] ax, bx, p;
    if (maj == 6'h24) begin
      p = {32'b0, a} * {{48{imm[15]}}, imm};
      return p[31:0];
    end
    case (ext)
      6'h27: begin p = {32'b0, a} * {32'b0, b}; return p[31:0]; end
      6'h07: begin ax = {32'b0, a}; bx = {32'b0, b}; end
      6'h17: begin ax = {{32{a[31]}}, a}; bx = {32'b0, b}; end
      default: begin ax = {{32{a[31]}}, a}; bx = {{32{b[31]}}, b}; end
    endcase
    p = ax * bx;
    return p[63:32];
  endfunction

  task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [5:0] maj, input logic [5:0] ext, input logic [W-1:0] a,
                        input logic [W-1:0] b, input logic [15:0] imm, input string req);
    logic [W-1:0] exp;
    int n;
    exp = model(maj, ext, a, b, imm);
    @(negedge clk);
    req_major = maj; req_ext = ext; req_a = a; req_b = b; req_imm = imm;
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    while (!res_valid && n < 100) begin
      @(negedge clk);
      n++;
    end
    check(n == W + 1, "R7 latency", W'(n), W'(W + 1));
    check(res_data == exp, req, res_data, exp);
    @(negedge clk);
    check(!res_valid && req_ready, "R8 R9 pulse ends, ready back",
          {30'b0, res_valid, req_ready}, 32'h1);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++; n_checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin : main
    logic [5:0] exts [5];
    int n;
    logic [W-1:0] held_exp;
    void'($urandom(32'd4242));
    exts[0] = 6'h27; exts[1] = 6'h07; exts[2] = 6'h17; exts[3] = 6'h1f; exts[4] = 6'h3c;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(req_ready == 1'b1, "R10 ready at reset", W'(req_ready), 1);
    check(res_valid == 1'b0, "R10 no result at reset", W'(res_valid), 0);
    rst_n = 1'b1;

    run_op(6'h3a, 6'h27, 32'd43, 32'd7, 16'h0, "R1 low 43*7");
    run_op(6'h3a, 6'h27, 32'hffffffff, 32'hffffffff, 16'h0, "R1 low all ones");
    run_op(6'h24, 6'h00, 32'd1000, 32'h12345678, 16'hfffd, "R2 imm negative");
    run_op(6'h24, 6'h07, 32'h80000001, 32'h0, 16'h7fff, "R2 imm positive, ext unused");
    run_op(6'h3a, 6'h07, 32'hffffffff, 32'hffffffff, 16'h0, "R3 uu all ones");
    run_op(6'h3a, 6'h07, 32'h80000000, 32'h2, 16'h0, "R3 uu carry");
    run_op(6'h3a, 6'h17, 32'hffffffff, 32'hffffffff, 16'h0, "R4 su neg A");
    run_op(6'h3a, 6'h17, 32'h7fffffff, 32'h80000000, 16'h0, "R4 su pos A");
    run_op(6'h3a, 6'h1f, 32'h80000000, 32'h80000000, 16'h0, "R5 ss min*min");
    run_op(6'h3a, 6'h1f, 32'hfffffffe, 32'h00000003, 16'h0, "R5 ss mixed sign");
    run_op(6'h3a, 6'h1f, 32'h0, 32'h80000000, 16'h0, "R5 ss zero");
    run_op(6'h3a, 6'h00, 32'h80000000, 32'hffffffff, 16'h0, "R6 unknown ext");
    run_op(6'h11, 6'h17, 32'hdeadbeef, 32'hcafef00d, 16'h0, "R6 register form other major");

    for (int i = 0; i < 60; i++) begin
      logic [5:0] e, m;
      e = exts[$urandom_range(4, 0)];
      m = ($urandom_range(3, 0) == 0) ? 6'h24 : 6'h3a;
      run_op(m, e, $urandom(), $urandom(), 16'($urandom()),
             (m == 6'h24) ? "R2 random imm" :
             (e == 6'h27) ? "R1 random" : (e == 6'h07) ? "R3 random" :
             (e == 6'h17) ? "R4 random" : (e == 6'h1f) ? "R5 random" : "R6 random");
    end

    // R9: hold a different request while busy
    held_exp = model(6'h3a, 6'h1f, 32'h91a2b3c4, 32'hf00dcafe, 16'h0);
    @(negedge clk);
    req_major = 6'h3a; req_ext = 6'h1f; req_a = 32'h91a2b3c4; req_b = 32'hf00dcafe;
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_ext = 6'h27; req_a = 32'h5; req_b = 32'h6;
    check(req_ready == 1'b0, "R9 busy after accept", W'(req_ready), 0);
    n = 0;
    while (!res_valid && n < 100) begin
      @(negedge clk);
      n++;
      if (n == 20) req_valid = 1'b0;
    end
    check(res_data == held_exp, "R9 busy request ignored", res_data, held_exp);
    n = 0;
    repeat (40) begin
      @(negedge clk);
      if (res_valid) n++;
    end
    check(n == 0, "R9 no extra result", W'(n), 0);

    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule